// File: doc/BRIEF.md
# Pre-add multiply-accumulate slice

This block is a three-stage signed arithmetic slice. A pre-adder first combines two 27-bit signed operands. A signed multiplier then scales that result by an 18-bit operand. A 48-bit post-adder finally adds the product to an external operand, subtracts that operand, feeds the product straight through, or adds the product to its own previous output to accumulate. A register can sit after each of the four points: inputs, pre-adder, multiplier and post-adder. A parameter keeps or removes each register when the design is elaborated, and each kept register has its own clock enable and its own synchronous clear.

The pre-adder operation and the post-adder operation are chosen at run time by two mode inputs. Both modes are captured together with the data, so a new mode applies exactly to the sample presented with it. A datapath built from chained slices can therefore change its arithmetic from one sample to the next without draining the pipeline first.

Top module: `premac_slice`

## Requirements
- R1: With all four registers kept and all enables high, a sample presented before rising edge k appears on p_o after edge k+3. The output does not change on the sample one edge earlier.
- R2: pre_mode_i selects the pre-adder result: 2'b00 gives d+a, 2'b01 gives d-a, and 2'b10 or 2'b11 give a alone with d_i ignored. The result is 27-bit signed and wraps modulo 2^27.
- R3: The multiplier forms the signed product of the 27-bit pre-adder result and the signed b_i. The product is sign-extended to 48 bits.
- R4: post_mode_i selects the output: 2'b00 gives M+C, 2'b01 gives M-C, 2'b10 gives P+M (accumulate on the registered output), and 2'b11 gives M with c_i ignored. All results wrap modulo 2^48.
- R5: A synchronous clear input empties only its own stage register at the next edge. It overrides that stage's clock enable and the accumulate feedback.
- R6: While a stage's clock enable is low and its clear is low, that stage register holds its value. Stages downstream of it go on working on the held value.
- R7: Both mode inputs travel with their sample through the pipeline. When consecutive samples carry different modes, each sample is computed with its own modes.
- R8: With rst_ni low, every register is cleared asynchronously, so p_o reads 0.
- R9: Each register can be removed at elaboration. Removing the input and pre-adder registers cuts the latency to two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 27 | Signed pre-adder operand A |
| d_i | input | 27 | Signed pre-adder operand D |
| b_i | input | 18 | Signed multiplier operand |
| c_i | input | 48 | Post-adder external operand |
| pre_mode_i | input | 2 | Pre-adder operation select |
| post_mode_i | input | 2 | Post-adder operation select |
| ce_in_i | input | 1 | Clock enable, input register |
| ce_pre_i | input | 1 | Clock enable, pre-adder register |
| ce_mul_i | input | 1 | Clock enable, multiplier register |
| ce_out_i | input | 1 | Clock enable, output register |
| srst_in_i | input | 1 | Synchronous clear, input register |
| srst_pre_i | input | 1 | Synchronous clear, pre-adder register |
| srst_mul_i | input | 1 | Synchronous clear, multiplier register |
| srst_out_i | input | 1 | Synchronous clear, output register |
| p_o | output | 48 | Post-adder result |

## Verification
Accumulation and the output clear can meet in the same cycle. The bench provokes this by pulsing srst_out_i for one cycle while the slice is in the middle of a running sum in accumulate mode. It judges the result by requiring p_o to read zero right after that edge and then to read exactly one product on the next edge, so the sum restarts from an empty register. A second overlap is a mode change arriving in the cycle right after a sample with different modes. The bench checks both samples at their own output cycles.

// File: rtl/premac_pkg.sv
package premac_pkg;
  typedef enum logic [1:0] {
    PRE_D_PLUS_A  = 2'b00,
    PRE_D_MINUS_A = 2'b01,
    PRE_A_ONLY    = 2'b10,
    PRE_A_ONLY_X  = 2'b11
  } pre_op_e;

  typedef enum logic [1:0] {
    POST_ADD_C = 2'b00,
    POST_SUB_C = 2'b01,
    POST_ACC   = 2'b10,
    POST_PASS  = 2'b11
  } post_op_e;
endpackage

// File: rtl/premac_pipe_reg.sv
module premac_pipe_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         srst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_q <= '0;
        else if (srst_i) q_q <= '0;
        else if (ce_i)   q_q <= d_i;
      end
      assign q_o = q_q;

      AST_SRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_i |=> (q_o == '0)) else $error("stage not cleared"); // R5
      AST_CE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ce_i && !srst_i) |=> $stable(q_o)) else $error("stage moved while disabled"); // R6
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = ^{clk_i, rst_ni, ce_i, srst_i};
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/premac_pre_adder.sv
module premac_pre_adder import premac_pkg::*; #(
  parameter int W = 27
) (
  input  logic [1:0]          op_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] d_i,
  output logic signed [W-1:0] ad_o
);
  always_comb begin
    case (pre_op_e'(op_i))
      PRE_D_PLUS_A:  ad_o = d_i + a_i;
      PRE_D_MINUS_A: ad_o = d_i - a_i;
      default:       ad_o = a_i;
    endcase
  end

  always_comb begin
    if (op_i == PRE_D_PLUS_A)
      AST_PRE_SUM: assert (W'(ad_o - a_i) == d_i) else $error("pre-add sum"); // R2
    if (op_i == PRE_D_MINUS_A)
      AST_PRE_DIFF: assert (W'(ad_o + a_i) == d_i) else $error("pre-add diff"); // R2
  end
endmodule

// File: rtl/premac_mult.sv
module premac_mult #(
  parameter int AW = 27,
  parameter int BW = 18,
  parameter int MW = AW + BW
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [MW-1:0] m_o
);
  logic signed [MW-1:0] a_x, b_x;
  assign a_x = MW'(a_i);
  assign b_x = MW'(b_i);
  assign m_o = a_x * b_x;

  always_comb begin
    if (a_i != '0 && b_i != '0)
      AST_MUL_SIGN: assert (m_o[MW-1] == (a_i[AW-1] ^ b_i[BW-1])) else $error("product sign"); // R3
  end
endmodule

// File: rtl/premac_post_adder.sv
module premac_post_adder import premac_pkg::*; #(
  parameter int W = 48
) (
  input  logic [1:0]   op_i,
  input  logic [W-1:0] m_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] fb_i,
  output logic [W-1:0] p_o
);
  always_comb begin
    case (post_op_e'(op_i))
      POST_ADD_C: p_o = m_i + c_i;
      POST_SUB_C: p_o = m_i - c_i;
      POST_ACC:   p_o = fb_i + m_i;
      default:    p_o = m_i;
    endcase
  end

  always_comb begin
    if (op_i == POST_ACC)
      AST_POST_ACC: assert (W'(p_o - m_i) == fb_i) else $error("accumulate"); // R4
  end
endmodule

// File: rtl/premac_slice.sv
module premac_slice #(
  parameter int AW      = 27,
  parameter int BW      = 18,
  parameter int PW      = 48,
  parameter bit IN_REG  = 1'b1,
  parameter bit PRE_REG = 1'b1,
  parameter bit MUL_REG = 1'b1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] d_i,
  input  logic [BW-1:0] b_i,
  input  logic [PW-1:0] c_i,
  input  logic [1:0]    pre_mode_i,
  input  logic [1:0]    post_mode_i,
  input  logic          ce_in_i,
  input  logic          ce_pre_i,
  input  logic          ce_mul_i,
  input  logic          ce_out_i,
  input  logic          srst_in_i,
  input  logic          srst_pre_i,
  input  logic          srst_mul_i,
  input  logic          srst_out_i,
  output logic [PW-1:0] p_o
);
  localparam int MW   = AW + BW;
  localparam int S1_W = 2 + 2 + PW + BW + AW + AW;
  localparam int S2_W = 2 + PW + BW + AW;
  localparam int S3_W = 2 + PW + MW;

  // input stage
  logic [S1_W-1:0] s1_d, s1_q;
  logic [AW-1:0]   s1_a, s1_d_op;
  logic [BW-1:0]   s1_b;
  logic [PW-1:0]   s1_c;
  logic [1:0]      s1_pre, s1_post;

  assign s1_d = {pre_mode_i, post_mode_i, c_i, b_i, d_i, a_i};
  premac_pipe_reg #(.W(S1_W), .EN(IN_REG)) u_in_reg (
    .clk_i, .rst_ni, .ce_i(ce_in_i), .srst_i(srst_in_i), .d_i(s1_d), .q_o(s1_q));
  assign {s1_pre, s1_post, s1_c, s1_b, s1_d_op, s1_a} = s1_q;

  // pre-adder stage
  logic [AW-1:0]   ad;
  logic [S2_W-1:0] s2_d, s2_q;
  logic [AW-1:0]   s2_ad;
  logic [BW-1:0]   s2_b;
  logic [PW-1:0]   s2_c;
  logic [1:0]      s2_post;

  premac_pre_adder #(.W(AW)) u_pre (
    .op_i(s1_pre), .a_i(s1_a), .d_i(s1_d_op), .ad_o(ad));
  assign s2_d = {s1_post, s1_c, s1_b, ad};
  premac_pipe_reg #(.W(S2_W), .EN(PRE_REG)) u_pre_reg (
    .clk_i, .rst_ni, .ce_i(ce_pre_i), .srst_i(srst_pre_i), .d_i(s2_d), .q_o(s2_q));
  assign {s2_post, s2_c, s2_b, s2_ad} = s2_q;

  // multiplier stage
  logic [MW-1:0]   prod;
  logic [S3_W-1:0] s3_d, s3_q;
  logic [MW-1:0]   s3_m;
  logic [PW-1:0]   s3_c;
  logic [1:0]      s3_post;

  premac_mult #(.AW(AW), .BW(BW), .MW(MW)) u_mul (
    .a_i(s2_ad), .b_i(s2_b), .m_o(prod));
  assign s3_d = {s2_post, s2_c, prod};
  premac_pipe_reg #(.W(S3_W), .EN(MUL_REG)) u_mul_reg (
    .clk_i, .rst_ni, .ce_i(ce_mul_i), .srst_i(srst_mul_i), .d_i(s3_d), .q_o(s3_q));
  assign {s3_post, s3_c, s3_m} = s3_q;

  // post-adder stage
  logic [PW-1:0] m_ext, p_next, p_fb, p_q;

  assign m_ext = PW'($signed(s3_m));

  premac_post_adder #(.W(PW)) u_post (
    .op_i(s3_post), .m_i(m_ext), .c_i(s3_c), .fb_i(p_fb), .p_o(p_next));
  premac_pipe_reg #(.W(PW), .EN(OUT_REG)) u_out_reg (
    .clk_i, .rst_ni, .ce_i(ce_out_i), .srst_i(srst_out_i), .d_i(p_next), .q_o(p_q));

  // feedback only exists when the output is registered
  generate
    if (OUT_REG) begin : g_fb
      assign p_fb = p_q;
    end else begin : g_no_fb
      assign p_fb = '0;
    end
  endgenerate

  assign p_o = p_q;
endmodule

// File: tb/premac_slice_tb.sv
module premac_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [26:0] a, d;
  logic [17:0] b;
  logic [47:0] c;
  logic [1:0]  pm, qm;
  logic        ce_in = 1, ce_pre = 1, ce_mul = 1, ce_out = 1;
  logic        sr_in = 0, sr_pre = 0, sr_mul = 0, sr_out = 0;
  logic [47:0] p, p_lo;
  int          n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  premac_slice dut_i (
    .clk_i(clk), .rst_ni, .a_i(a), .d_i(d), .b_i(b), .c_i(c),
    .pre_mode_i(pm), .post_mode_i(qm),
    .ce_in_i(ce_in), .ce_pre_i(ce_pre), .ce_mul_i(ce_mul), .ce_out_i(ce_out),
    .srst_in_i(sr_in), .srst_pre_i(sr_pre), .srst_mul_i(sr_mul), .srst_out_i(sr_out),
    .p_o(p));

  premac_slice #(.IN_REG(1'b0), .PRE_REG(1'b0)) dut_lo_i (
    .clk_i(clk), .rst_ni, .a_i(a), .d_i(d), .b_i(b), .c_i(c),
    .pre_mode_i(pm), .post_mode_i(qm),
    .ce_in_i(1'b1), .ce_pre_i(1'b1), .ce_mul_i(1'b1), .ce_out_i(1'b1),
    .srst_in_i(1'b0), .srst_pre_i(1'b0), .srst_mul_i(1'b0), .srst_out_i(1'b0),
    .p_o(p_lo));

  function automatic logic [47:0] ref_p(input logic [26:0] fa, fd, input logic [17:0] fb,
                                        input logic [47:0] fc, input logic [1:0] fpm, fqm,
                                        input logic [47:0] fpv);
    logic [26:0] ad;
    logic [47:0] m;
    case (fpm)
      2'd0:    ad = fd + fa;
      2'd1:    ad = fd - fa;
      default: ad = fa;
    endcase
    m = 48'($signed(ad)) * 48'($signed(fb));
    case (fqm)
      2'd0:    return m + fc;
      2'd1:    return m - fc;
      2'd2:    return fpv + m;
      default: return m;
    endcase
  endfunction

  task automatic check(input string req, input logic [47:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [26:0] ta, td, input logic [17:0] tb,
                       input logic [47:0] tc, input logic [1:0] tpm, tqm);
    a = ta; d = td; b = tb; c = tc; pm = tpm; qm = tqm;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush;
    drive('0, '0, '0, '0, 2'd0, 2'd3);
    wait_n(5);
  endtask

  task automatic t_reset;
    check("R8 reset p_o", p, 48'd0);
    check("R8 reset p_o (short pipe)", p_lo, 48'd0);
  endtask

  task automatic t_pre_modes;
    drive(27'd100, 27'd40, 18'd3, 48'd999, 2'd0, 2'd3);
    wait_n(4); check("R2 d+a", p, ref_p(27'd100, 27'd40, 18'd3, 48'd999, 2'd0, 2'd3, '0));
    drive(27'd100, 27'd40, -18'sd7, 48'd999, 2'd1, 2'd3);
    wait_n(4); check("R2 d-a negative b R3", p, 48'sd420);
    drive(-27'sd12345, 27'd777, 18'd11, 48'd5, 2'd2, 2'd3);
    wait_n(4); check("R2 a only", p, 48'(-48'sd135795));
    drive(-27'sd12345, 27'd31, 18'd11, 48'd5, 2'd3, 2'd3);
    wait_n(4); check("R2 a only, d ignored", p, 48'(-48'sd135795));
    drive(27'h3FF_FFFF, 27'd1, 18'd1, 48'd0, 2'd0, 2'd3);
    wait_n(4); check("R2 pre-add wrap", p, 48'hFFFF_FC00_0000);
    drive(27'h400_0000, 27'd0, 18'h2_0000, 48'd0, 2'd2, 2'd3);
    wait_n(4); check("R3 most negative product", p, 48'h0800_0000_0000);
  endtask

  task automatic t_post_modes;
    drive(27'd6, 27'd0, 18'd7, 48'd1000, 2'd2, 2'd0);
    wait_n(4); check("R4 M+C", p, 48'd1042);
    drive(27'd6, 27'd0, 18'd7, 48'd1000, 2'd2, 2'd1);
    wait_n(4); check("R4 M-C", p, 48'(-48'sd958));
    drive(27'd1, 27'd0, 18'd1, 48'h7FFF_FFFF_FFFF, 2'd2, 2'd0);
    wait_n(4); check("R4 post-add wrap", p, 48'h8000_0000_0000);
    drive(27'd6, 27'd0, 18'd7, 48'h1234, 2'd2, 2'd3);
    wait_n(4); check("R4 pass, c ignored", p, 48'd42);
  endtask

  task automatic t_stream;
    flush();
    drive(27'd9, 27'd4, 18'd5, 48'd50, 2'd0, 2'd0);
    wait_n(1);
    drive(27'd9, 27'd4, 18'd5, 48'd50, 2'd1, 2'd1);
    wait_n(2); check("R1 not yet at edge 3", p, 48'd0);
    wait_n(1); check("R1 R7 first sample", p, 48'd115);
    wait_n(1); check("R7 second sample own modes", p, 48'(-48'sd75));
  endtask

  task automatic t_accumulate;
    logic [47:0] m;
    flush();
    m = ref_p(27'd5, 27'd2, -18'sd3, '0, 2'd0, 2'd3, '0);
    drive(27'd5, 27'd2, -18'sd3, 48'd77, 2'd0, 2'd2);
    wait_n(4); check("R4 acc 1x", p, m);
    wait_n(1); check("R4 acc 2x", p, 48'(2 * m));
    wait_n(1); check("R4 acc 3x", p, 48'(3 * m));
    sr_out = 1;
    wait_n(1); sr_out = 0;
    check("R5 clear beats accumulate", p, 48'd0);
    wait_n(1); check("R5 accumulate restarts", p, m);
  endtask

  task automatic t_ce;
    flush();
    drive(27'd3, 27'd0, 18'd4, 48'd1, 2'd2, 2'd0);
    wait_n(4); check("R6 preload", p, 48'd13);
    ce_out = 0;
    drive(27'd3, 27'd0, 18'd4, 48'd1, 2'd2, 2'd1);
    wait_n(5); check("R6 out hold", p, 48'd13);
    ce_out = 1;
    wait_n(1); check("R6 out resumes", p, 48'd11);
    ce_in = 0;
    drive(27'd8, 27'd0, 18'd8, 48'd0, 2'd2, 2'd3);
    wait_n(5); check("R6 input hold", p, 48'd11);
    ce_in = 1;
    wait_n(4); check("R6 input resumes", p, 48'd64);
  endtask

  task automatic t_srst_in;
    drive(27'd10, 27'd0, 18'd10, 48'd5, 2'd2, 2'd0);
    wait_n(5); check("R5 preload", p, 48'd105);
    sr_in = 1;
    wait_n(1); sr_in = 0;
    wait_n(2); check("R5 other stages untouched", p, 48'd105);
    wait_n(1); check("R5 cleared sample reaches p", p, 48'd0);
    wait_n(1); check("R5 data returns", p, 48'd105);
  endtask

  task automatic t_bypass;
    flush();
    drive(27'd7, 27'd0, 18'd6, 48'd0, 2'd2, 2'd3);
    wait_n(1); check("R9 short pipe not yet", p_lo, 48'd0);
    wait_n(1); check("R9 short pipe latency 2", p_lo, 48'd42);
  endtask

  initial begin
    drive('0, '0, '0, '0, 2'd0, 2'd3);
    wait_n(3);
    t_reset();
    rst_ni = 1;
    wait_n(1);
    t_pre_modes();
    t_post_modes();
    t_stream();
    t_accumulate();
    t_ce();
    t_srst_in();
    t_bypass();
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
    $finish;
  end
endmodule